// File: doc/BRIEF.md
# SPI Master with Same-Edge Phase Option

This block is a buffered SPI master. A message of up to `BUF_BYTES` bytes is written into an internal transmit buffer. A single start pulse then shifts the whole message out on MOSI while MISO is shifted in. Each byte goes out most significant bit first. The SCLK half period is derived from the system clock frequency and a target SCLK frequency. The active-low slave select frames the transfer: it falls half an SCLK period before the first edge and rises half a period after the last edge.

A 32-bit control word sets three options: clock polarity, whether SCLK is gated while the slave is deselected, and a phase-extension option. Phase extension moves launch and latch onto the same SCLK edge, so the slave sees data launched and latched together. The word is used only when its valid flag is set. When the flag is clear, built-in defaults apply. The CPHA input always comes from the caller.

The first `prepend_cnt` bytes are treated as command bytes: they are transmitted, and whatever the slave returns during them is dropped. The bytes that follow are exchanged in both directions, and the received data is packed into the receive buffer starting at index 0. A one-cycle done pulse with a status code ends every request, including requests that are rejected.

Top module: `spi_xp_master`

## Requirements
- R1: After reset, ss_n is 1, done is 0, status is 0, mosi is 0 and sclk is at the default idle level 0.
- R2: A start with byte_cnt of 0 or greater than BUF_BYTES (512) gives done on the next cycle with status 1 (bad length), and ss_n stays 1. A byte_cnt of exactly BUF_BYTES is accepted.
- R3: A start with prepend_cnt greater than byte_cnt gives done on the next cycle with status 2 (error), and ss_n stays 1.
- R4: Every transmit-buffer byte 0..byte_cnt-1 appears on MOSI, MSB first. Receive byte j (for j >= prepend_cnt) is stored at receive address j - prepend_cnt. The bytes received during the prepend portion are not stored.
- R5: Edge k of a transfer (k = 0 first) is a leading edge when k is even. MISO is latched on edges whose parity equals CPHA. With phase extension off, MOSI is launched on the other edges. With phase extension on, the next MOSI bit is launched on the same edge as the latch, right after it. Bit 0 is driven before edge 0 unless CPHA=1 with phase extension off.
- R6: SCLK is at the polarity level (control-word bit 28 when the word is valid) when ss_n falls and when ss_n rises.
- R7: ss_n falls one cycle after start is sampled. The first SCLK edge comes HALF cycles after that, there are exactly 16*byte_cnt edges, and ss_n rises HALF cycles after the last edge. HALF is ceil(SYS_HZ/(2*SCLK_HZ)) with a minimum of 3, which gives 4 for the defaults.
- R8: done is a one-cycle pulse in the cycle ss_n rises, with status 0. status is 0 whenever done is 0.
- R9: While ss_n is 1, SCLK holds the polarity level when gating (control-word bit 29) is set. When gating is clear, SCLK toggles every HALF cycles.
- R10: When control-word bit 31 is 0, bits 30..28 are ignored and the defaults apply: no phase extension, gating on, polarity 0.
- R11: A start while a transfer is in progress is ignored, with no done and no status until the running transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a request (sampled in idle only) |
| ctrl_word | input | 32 | bit31 valid, bit30 phase extension, bit29 gate SCLK while deselected, bit28 polarity |
| cpha | input | 1 | Clock phase |
| byte_cnt | input | $clog2(BUF_BYTES+1) | Message length in bytes |
| prepend_cnt | input | $clog2(BUF_BYTES+1) | Leading transmit-only bytes |
| tx_we | input | 1 | Transmit buffer write enable |
| tx_addr | input | $clog2(BUF_BYTES) | Transmit buffer write address |
| tx_data | input | 8 | Transmit buffer write data |
| rx_addr | input | $clog2(BUF_BYTES) | Receive buffer read address |
| rx_data | output | 8 | Receive buffer data, one cycle after rx_addr |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| ss_n | output | 1 | Active-low slave select |
| done | output | 1 | One-cycle end-of-request pulse |
| status | output | 2 | 0 OK, 1 bad length, 2 error; valid with done |

## Verification
Rejections are due one cycle after start, so the bench samples done and status at the first falling clock edge after the start edge. For accepted transfers, the bench timestamps every output change at falling edges and checks the distances HALF, HALF and one cycle between start, slave select, first and last edge, and slave select release. The done pulse is checked in the same cycle as the slave-select release, and its absence in the cycle after. The bench slave latches MOSI from the value it held one cycle before the edge, so same-edge launches are judged on the pre-edge value. Receive-buffer reads are sampled one cycle after the address is applied.

// File: rtl/spi_xp_pkg.sv
`timescale 1ns/1ps
package spi_xp_pkg;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_BADLEN = 2'd1,
    ST_ERR    = 2'd2
  } xfer_status_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_TAIL = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic ext;
    logic gate;
    logic cpol;
    logic cpha;
  } spi_cfg_t;

  localparam int CW_VALID = 31;
  localparam int CW_EXT   = 30;
  localparam int CW_GATE  = 29;
  localparam int CW_CPOL  = 28;

endpackage

// File: rtl/spi_xp_ram.sv
`timescale 1ns/1ps
module spi_xp_ram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_xp_idleclk.sv
`timescale 1ns/1ps
module spi_xp_idleclk #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tgl
);
  localparam int W = $clog2(HALF + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      tgl <= 1'b0;
    end else if (cnt == W'(HALF - 1)) begin
      cnt <= '0;
      tgl <= ~tgl;
    end else begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/spi_xp_master.sv
`timescale 1ns/1ps
module spi_xp_master
  import spi_xp_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int SYS_HZ    = 250_000_000,
  parameter int SCLK_HZ   = 40_000_000,
  parameter bit DEF_EXT   = 1'b0,
  parameter bit DEF_GATE  = 1'b1,
  parameter bit DEF_CPOL  = 1'b0
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic [31:0]                      ctrl_word,
  input  logic                             cpha,
  input  logic [$clog2(BUF_BYTES+1)-1:0]   byte_cnt,
  input  logic [$clog2(BUF_BYTES+1)-1:0]   prepend_cnt,
  input  logic                             tx_we,
  input  logic [$clog2(BUF_BYTES)-1:0]     tx_addr,
  input  logic [7:0]                       tx_data,
  input  logic [$clog2(BUF_BYTES)-1:0]     rx_addr,
  output logic [7:0]                       rx_data,
  input  logic                             miso,
  output logic                             sclk,
  output logic                             mosi,
  output logic                             ss_n,
  output logic                             done,
  output logic [1:0]                       status
);
  localparam int AW       = $clog2(BUF_BYTES);
  localparam int CW       = $clog2(BUF_BYTES + 1);
  localparam int BW       = CW + 3;
  localparam int EW       = BW + 1;
  localparam int HALF_RAW = (SYS_HZ + 2 * SCLK_HZ - 1) / (2 * SCLK_HZ);
  localparam int HALF     = (HALF_RAW < 3) ? 3 : HALF_RAW;
  localparam int HW       = $clog2(HALF + 1);
  localparam logic [CW-1:0] BUF_C = CW'(BUF_BYTES);

  xfer_state_e    state;
  spi_cfg_t       cfg, dec_cfg;
  logic [HW-1:0]  hc;
  logic [EW-1:0]  k, nedges;
  logic [BW-1:0]  nbits, lp, lt;
  logic [CW-1:0]  pre_q, rx_idx;
  logic [7:0]     rx_sh, tx_q;
  logic           idle_tgl;
  logic           len_bad, pre_bad;
  logic           edge_now, latch_now, launch_now, predrive_now, rx_we;
  logic           ignore_unused;

  assign ignore_unused = ^{ctrl_word[27:0], rx_idx};

  // option decode: valid flag selects caller bits or built-in defaults
  always_comb begin
    if (ctrl_word[CW_VALID])
      dec_cfg = '{ext: ctrl_word[CW_EXT], gate: ctrl_word[CW_GATE],
                  cpol: ctrl_word[CW_CPOL], cpha: cpha};
    else
      dec_cfg = '{ext: DEF_EXT, gate: DEF_GATE, cpol: DEF_CPOL, cpha: cpha};
  end

  assign len_bad = (byte_cnt == '0) || (byte_cnt > BUF_C);
  assign pre_bad = (prepend_cnt > byte_cnt);

  // edge scheduling: leading edges have even index
  assign edge_now     = (state == S_RUN) && (hc == HW'(HALF - 1));
  assign latch_now    = edge_now && (k[0] == cfg.cpha);
  assign launch_now   = edge_now && (lp < nbits) &&
                        (cfg.ext ? (k[0] == cfg.cpha) : (k[0] != cfg.cpha));
  assign predrive_now = (state == S_RUN) && (k == '0) && (hc == HW'(1)) &&
                        !(cfg.cpha && !cfg.ext);

  assign rx_idx = lt[BW-1:3] - pre_q;
  assign rx_we  = latch_now && (lt[2:0] == 3'd7) && (lt[BW-1:3] >= pre_q);

  spi_xp_ram #(.DEPTH(BUF_BYTES), .WIDTH(8)) u_txbuf (
    .clk(clk), .we(tx_we), .waddr(tx_addr), .wdata(tx_data),
    .raddr(lp[AW+2:3]), .rdata(tx_q)
  );

  spi_xp_ram #(.DEPTH(BUF_BYTES), .WIDTH(8)) u_rxbuf (
    .clk(clk), .we(rx_we), .waddr(rx_idx[AW-1:0]), .wdata({rx_sh[6:0], miso}),
    .raddr(rx_addr), .rdata(rx_data)
  );

  spi_xp_idleclk #(.HALF(HALF)) u_idleclk (
    .clk(clk), .rst(rst), .tgl(idle_tgl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cfg    <= '{ext: DEF_EXT, gate: DEF_GATE, cpol: DEF_CPOL, cpha: 1'b0};
      hc     <= '0;
      k      <= '0;
      nedges <= '0;
      nbits  <= '0;
      lp     <= '0;
      lt     <= '0;
      pre_q  <= '0;
      rx_sh  <= '0;
      sclk   <= DEF_CPOL;
      mosi   <= 1'b0;
      ss_n   <= 1'b1;
      done   <= 1'b0;
      status <= ST_OK;
    end else begin
      done   <= 1'b0;
      status <= ST_OK;
      case (state)
        S_IDLE: begin
          sclk <= cfg.gate ? cfg.cpol : idle_tgl;
          if (start) begin
            if (len_bad) begin
              done   <= 1'b1;
              status <= ST_BADLEN;
            end else if (pre_bad) begin
              done   <= 1'b1;
              status <= ST_ERR;
            end else begin
              cfg    <= dec_cfg;
              sclk   <= dec_cfg.cpol;
              ss_n   <= 1'b0;
              state  <= S_RUN;
              hc     <= '0;
              k      <= '0;
              lp     <= '0;
              lt     <= '0;
              nbits  <= {byte_cnt, 3'b000};
              nedges <= {byte_cnt, 4'b0000};
              pre_q  <= prepend_cnt;
            end
          end
        end
        S_RUN: begin
          hc <= (hc == HW'(HALF - 1)) ? '0 : hc + HW'(1);
          if (edge_now) begin
            sclk <= ~sclk;
            k    <= k + EW'(1);
            if (k == nedges - EW'(1)) state <= S_TAIL;
          end
          if (latch_now) begin
            rx_sh <= {rx_sh[6:0], miso};
            lt    <= lt + BW'(1);
          end
          if (predrive_now || launch_now) begin
            mosi <= tx_q[3'd7 - lp[2:0]];
            lp   <= lp + BW'(1);
          end
        end
        S_TAIL: begin
          if (hc == HW'(HALF - 1)) begin
            hc     <= '0;
            ss_n   <= 1'b1;
            done   <= 1'b1;
            status <= ST_OK;
            state  <= S_IDLE;
          end else begin
            hc <= hc + HW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_xp_master_chk.sv
`timescale 1ns/1ps
module spi_xp_master_chk
  import spi_xp_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       ss_n,
  input logic       sclk,
  input logic       done,
  input logic [1:0] status,
  input spi_cfg_t   cfg_q
);
  logic chk_unused;
  assign chk_unused = cfg_q.ext ^ cfg_q.cpha;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_status_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> (status == 2'd0));

  assert_reject_keeps_ss_R2: assert property (@(posedge clk) disable iff (rst)
    (done && status != 2'd0) |-> (ss_n && $past(ss_n)));

  assert_end_reports_ok_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_n) |-> (done && status == 2'd0));

  assert_busy_no_done_R11: assert property (@(posedge clk) disable iff (rst)
    !ss_n |-> !done);

  assert_gate_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (ss_n && $past(ss_n) && cfg_q.gate && $past(cfg_q.gate))
      |-> ($stable(sclk) && sclk == cfg_q.cpol));
endmodule

bind spi_xp_master spi_xp_master_chk u_chk (
  .clk(clk), .rst(rst), .ss_n(ss_n), .sclk(sclk),
  .done(done), .status(status), .cfg_q(cfg)
);

// File: tb/spi_xp_master_bench.sv
`timescale 1ns/1ps
module spi_xp_master_bench;
  localparam int HALF = 4;  // ceil(250e6 / (2 * 40e6)), R7

  logic       clk = 1'b0, rst = 1'b1, start = 1'b0, cpha = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic [9:0] byte_cnt = '0, prepend_cnt = '0;
  logic       tx_we = 1'b0;
  logic [8:0] tx_addr = '0, rx_addr = '0;
  logic [7:0] tx_data = '0, rx_data;
  logic       miso = 1'b0, sclk, mosi, ss_n, done;
  logic [1:0] status;

  spi_xp_master u_spi_xp_master (
    .clk(clk), .rst(rst), .start(start), .ctrl_word(ctrl_word), .cpha(cpha),
    .byte_cnt(byte_cnt), .prepend_cnt(prepend_cnt), .tx_we(tx_we),
    .tx_addr(tx_addr), .tx_data(tx_data), .rx_addr(rx_addr), .rx_data(rx_data),
    .miso(miso), .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .done(done), .status(status)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tdat(input int s, input int j);
    return 8'((j * 13 + s * 29 + 1) ^ 8'h3C);
  endfunction
  function automatic logic [7:0] sdat(input int s, input int j);
    return 8'((j * 37 + s * 11) ^ 8'hA5);
  endfunction

  // scoreboard of MOSI bytes expected at the slave
  logic [7:0] exp_q[$];

  // slave model and timing monitor, sampled at falling clock edges
  bit s_cpha, s_ext;
  int s_seed, s_nbits, s_k, s_lt, s_ls, edges;
  int ss_fall_cyc, first_edge_cyc, last_edge_cyc, ss_rise_cyc;
  logic sclk_at_fall, sclk_at_rise;
  logic [7:0] s_rx;
  logic ss_prev = 1'b1, sclk_prev = 1'b0, mosi_prev = 1'b0;

  function automatic logic sbit(input int i);
    logic [7:0] b;
    b = sdat(s_seed, i / 8);
    return b[7 - (i % 8)];
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (ss_prev && !ss_n) begin
        s_k = 0; s_lt = 0; s_ls = 0; edges = 0;
        ss_fall_cyc = cyc; sclk_at_fall = sclk;
        if (!(s_cpha && !s_ext)) begin
          miso = sbit(0);
          s_ls = 1;
        end
      end else if (!ss_n && sclk != sclk_prev) begin
        if (edges == 0) first_edge_cyc = cyc;
        last_edge_cyc = cyc;
        if (s_k[0] == s_cpha) begin
          s_rx = {s_rx[6:0], mosi_prev};
          s_lt++;
          if (s_lt % 8 == 0) begin
            if (exp_q.size() == 0) check(1'b0, "R4 unexpected MOSI byte", int'(s_rx), -1);
            else begin
              logic [7:0] e;
              e = exp_q.pop_front();
              check(s_rx == e, "R5 MOSI byte", int'(s_rx), int'(e));
            end
          end
        end
        if (s_ls < s_nbits && (s_ext ? (s_k[0] == s_cpha) : (s_k[0] != s_cpha))) begin
          miso = sbit(s_ls);
          s_ls++;
        end
        s_k++;
        edges++;
      end
      if (!ss_prev && ss_n) begin
        ss_rise_cyc = cyc;
        sclk_at_rise = sclk;
      end
    end
    ss_prev = ss_n; sclk_prev = sclk; mosi_prev = mosi;
  end

  task automatic xfer(input int n, input int pre, input logic [31:0] cw, input bit ph,
                      input bit ecpol, input bit eext, input int seed, input bit poke);
    int c0, guard;
    logic [7:0] v;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      tx_we = 1'b1; tx_addr = 9'(j); tx_data = tdat(seed, j);
      exp_q.push_back(tdat(seed, j));
    end
    @(negedge clk);
    tx_we = 1'b0;
    s_cpha = ph; s_ext = eext; s_seed = seed; s_nbits = n * 8;
    start = 1'b1; byte_cnt = 10'(n); prepend_cnt = 10'(pre); ctrl_word = cw; cpha = ph;
    c0 = cyc;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 40000) begin
      @(negedge clk);
      guard++;
      if (poke && guard == 10) begin start = 1'b1; byte_cnt = 10'd0; end
      else start = 1'b0;
    end
    start = 1'b0;
    check(done == 1'b1, "R8 done seen", int'(done), 1);
    check(status == 2'd0, poke ? "R11 status of busy start" : "R8 status", int'(status), 0);
    check(ss_n == 1'b1, "R8 done with ss_n rise", int'(ss_n), 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", int'(done), 0);
    check(ss_fall_cyc == c0 + 1, "R7 ss_n fall delay", ss_fall_cyc - c0, 1);
    check(edges == 16 * n, "R7 edge count", edges, 16 * n);
    check(first_edge_cyc - ss_fall_cyc == HALF, "R7 lead time", first_edge_cyc - ss_fall_cyc, HALF);
    check(ss_rise_cyc - last_edge_cyc == HALF, "R7 trail time", ss_rise_cyc - last_edge_cyc, HALF);
    check(sclk_at_fall == ecpol, "R6 sclk at ss_n fall", int'(sclk_at_fall), int'(ecpol));
    check(sclk_at_rise == ecpol, "R6 sclk at ss_n rise", int'(sclk_at_rise), int'(ecpol));
    check(exp_q.size() == 0, "R4 all MOSI bytes seen", exp_q.size(), 0);
    exp_q.delete();
    for (int j = pre; j < n; j++) begin
      @(negedge clk);
      rx_addr = 9'(j - pre);
      @(negedge clk);
      v = rx_data;
      check(v == sdat(seed, j), "R4 R5 rx buffer byte", int'(v), int'(sdat(seed, j)));
    end
  endtask

  task automatic reject(input int n, input int pre, input int exp_st, input string req);
    @(negedge clk);
    start = 1'b1; byte_cnt = 10'(n); prepend_cnt = 10'(pre); ctrl_word = 32'h8000_0000;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, req, int'(done), 1);
    check(int'(status) == exp_st, req, int'(status), exp_st);
    check(ss_n == 1'b1, req, int'(ss_n), 1);
    @(negedge clk);
    check(done == 1'b0 && ss_n == 1'b1, req, int'(done), 0);
  endtask

  task automatic idle_watch(input bit gate, input bit cpol, input string req);
    int changes;
    logic last;
    repeat (3 * HALF) @(negedge clk);
    last = sclk; changes = 0;
    repeat (8 * HALF) begin
      @(negedge clk);
      if (sclk != last) changes++;
      last = sclk;
    end
    check(changes == (gate ? 0 : 8), req, changes, gate ? 0 : 8);
    if (gate) check(sclk == cpol, req, int'(sclk), int'(cpol));
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ss_n == 1'b1, "R1 ss_n", int'(ss_n), 1);
    check(done == 1'b0 && status == 2'd0, "R1 done/status", int'(done), 0);
    check(sclk == 1'b0 && mosi == 1'b0, "R1 sclk/mosi", int'(sclk), 0);
    idle_watch(1'b1, 1'b0, "R9 R10 default idle gated");

    // all polarity / phase / extension combinations, gating on
    for (int m = 0; m < 8; m++) begin
      bit ex, po, ph;
      ex = m[2]; po = m[1]; ph = m[0];
      xfer(3, 1, {1'b1, ex, 1'b1, po, 28'h0}, ph, po, ex, m + 1, 1'b0);
      idle_watch(1'b1, po, "R9 gated idle level");
    end

    // gating off: free-running SCLK while deselected
    xfer(4, 0, {1'b1, 1'b0, 1'b0, 1'b1, 28'h0}, 1'b0, 1'b1, 1'b0, 20, 1'b0);
    idle_watch(1'b0, 1'b1, "R9 ungated idle toggles");

    // valid flag clear: bits 30 and 28 set but ignored, gating default on
    xfer(3, 0, 32'h5000_0000, 1'b1, 1'b0, 1'b0, 31, 1'b0);
    idle_watch(1'b1, 1'b0, "R10 defaults applied");

    // full buffer, and prepend covering the whole message
    xfer(512, 2, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 7, 1'b0);
    xfer(2, 2, 32'hC000_0000, 1'b0, 1'b0, 1'b1, 9, 1'b0);

    reject(0, 0, 1, "R2 zero length");
    reject(513, 0, 1, "R2 over length");
    reject(3, 5, 2, "R3 prepend too long");

    // start during a transfer is ignored
    xfer(2, 0, 32'hA000_0000, 1'b1, 1'b0, 1'b0, 12, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule